// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a byte-wide memory that is accessed only in sequence. A writer and a reader each have their own clock, their own address counter and their own reset. The bytes come back out in the order they went in. No full or empty tracking exists. The delay between the two streams depends only on when each side pulses its reset. A typical use is a one-field video delay, where the write reset marks the start of the incoming field and the read reset is issued some time later.

Each side has two qualifiers. The step enable gates both the access and the address advance. The second qualifier blocks only the data, and the address still moves:

- On the write side it blocks the store. A stream can then overwrite only chosen regions, for example to insert a small picture.
- On the read side it forces the output to zero.

Storage is an inferred two-clock RAM of parameterised depth. A full-field configuration uses a depth of 262,144 words. A smaller default keeps elaboration light.

Top module: `fdm_delay_mem`

## Requirements
- R1: Words written at consecutive addresses are returned by the read side in the same order.
- R2: The write and read sides run on unrelated clocks, which may have different periods, and neither side's timing affects the other.
- R3: A reset on a rising edge sets that side's address to 0. If the step enable is high on the same edge, the access uses address 0 and the address becomes 1; otherwise the address stays at 0. For a read, the word from address 0 appears on `rd_data` after that same edge. A read reset with the step enable low leaves `rd_data` unchanged.
- R4: With `wr_step_en` low (and no reset), a write edge stores nothing and leaves the write address unchanged.
- R5: With `rd_step_en` low (and no reset), a read edge leaves `rd_data` and the read address unchanged.
- R6: With `wr_step_en` high and `wr_store_en` low, the addressed word keeps its old contents and the write address advances by one.
- R7: With `rd_step_en` high and `rd_drive_en` low, `rd_data` reads 8'h00 after the edge and the read address advances by one.
- R8: Both addresses wrap from DEPTH-1 back to 0.
- R9: If the read reset is issued after N writes into a continuous stream, the read side returns the stream starting from its first word, lagging the writer by N positions.
- R10: Either clock may stop for any length of time. Stored words and the address position are kept, and access resumes where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write address reset |
| wr_step_en | input | 1 | Write access and address advance enable |
| wr_store_en | input | 1 | Store qualifier; low keeps the addressed word |
| wr_data | input | DW | Write data |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous read address reset |
| rd_step_en | input | 1 | Read access and address advance enable |
| rd_drive_en | input | 1 | Output qualifier; low forces zero output |
| rd_data | output | DW | Registered read data |

## Verification
The hardest case to reach is a write and a read running at the same time on clocks with different periods. A real delay is then measured, not two separate phases. The bench writes a continuous stream on the fast clock and issues the read reset four writes into it. It then reads on a slower clock, so the reader always stays behind the writer and never touches the location being written. Masked stores are also hard to observe. They can only be seen after an earlier full pass has filled memory with known bytes, so a skipped location reads back its old value rather than undefined data.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
    // Result of a read that targets the word being written in the same cycle
    typedef enum logic {
        COLL_OLD = 1'b0,
        COLL_NEW = 1'b1
    } coll_mode_e;
endpackage

// File: rtl/fdm_wr_port.sv
module fdm_wr_port #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          store_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [AW-1:0] sel;

    always_comb begin
        st_d     = st_q;
        sel      = rst ? '0 : st_q.addr;
        mem_addr = sel;
        mem_we   = step_en & store_en;
        if (rst || step_en) begin
            if (step_en) st_d.addr = (sel == LAST) ? '0 : sel + 1'b1;
            else         st_d.addr = sel;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Checks: armed once the first reset has positioned the counter
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b1;
    end

    p_wr_zero_r3: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        rst && !step_en |=> st_q.addr == '0);
    p_wr_first_r3: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        rst && step_en |=> st_q.addr == AW'(1));
    p_wr_hold_r4: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        !rst && !step_en |=> $stable(st_q.addr));
    p_wr_mask_adv_r6: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        !rst && step_en && !store_en && st_q.addr != LAST |=> st_q.addr == $past(st_q.addr) + 1'b1);
    p_wr_wrap_r8: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        !rst && step_en && st_q.addr == LAST |=> st_q.addr == '0);
endmodule

// File: rtl/fdm_rd_port.sv
module fdm_rd_port #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          drive_en,
    input  logic [DW-1:0] mem_q,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          drive;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [AW-1:0] sel;

    always_comb begin
        st_d     = st_q;
        sel      = rst ? '0 : st_q.addr;
        mem_addr = sel;
        mem_re   = step_en;
        if (rst || step_en) begin
            if (step_en) begin
                st_d.addr  = (sel == LAST) ? '0 : sel + 1'b1;
                st_d.drive = drive_en;
            end else begin
                st_d.addr  = sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data = st_q.drive ? mem_q : '0;

    // Checks: armed once the first reset has positioned the counter
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b1;
    end

    p_rd_first_r3: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        rst && step_en |=> st_q.addr == AW'(1));
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        !rst && !step_en |=> $stable(st_q.addr) && $stable(rd_data));
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        step_en && !drive_en |=> rd_data == '0);
    p_rd_wrap_r8: assert property (@(posedge clk) disable iff (live_q !== 1'b1)
        !rst && step_en && st_q.addr == LAST |=> st_q.addr == '0);
endmodule

// File: rtl/fdm_ram.sv
module fdm_ram
    import fdm_pkg::*;
#(
    parameter int         DEPTH = 2048,
    parameter int         DW    = 8,
    parameter coll_mode_e COLL  = COLL_OLD,
    localparam int        AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_src;

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    generate
        if (COLL == COLL_NEW) begin : g_bypass
            assign rd_src = (wr_en && wr_addr == rd_addr) ? wr_data : mem[rd_addr];
        end else begin : g_plain
            assign rd_src = mem[rd_addr];
        end
    endgenerate

    always_ff @(posedge rd_clk) begin
        if (rd_en) rd_q <= rd_src;
    end
endmodule

// File: rtl/fdm_delay_mem.sv
module fdm_delay_mem
    import fdm_pkg::*;
#(
    parameter int         DEPTH = 2048,
    parameter int         DW    = 8,
    parameter coll_mode_e COLL  = COLL_OLD
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_step_en,
    input  logic          wr_store_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_step_en,
    input  logic          rd_drive_en,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic          w_en;
    logic [AW-1:0] w_addr;
    logic          r_en;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_q;

    fdm_wr_port #(.DEPTH(DEPTH)) u_wr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .step_en  (wr_step_en),
        .store_en (wr_store_en),
        .mem_we   (w_en),
        .mem_addr (w_addr)
    );

    fdm_ram #(.DEPTH(DEPTH), .DW(DW), .COLL(COLL)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (w_en),
        .wr_addr (w_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_en   (r_en),
        .rd_addr (r_addr),
        .rd_q    (r_q)
    );

    fdm_rd_port #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .step_en  (rd_step_en),
        .drive_en (rd_drive_en),
        .mem_q    (r_q),
        .mem_re   (r_en),
        .mem_addr (r_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/tb_fdm_delay_mem.sv
`timescale 1ns/1ps
module tb_fdm_delay_mem;
    localparam int D = 16;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_run = 1, rd_run = 1;
    logic wr_rst = 0, wr_step_en = 0, wr_store_en = 0;
    logic rd_rst = 0, rd_step_en = 0, rd_drive_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;

    always #2.5 if (wr_run) wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.5 if (rd_run) rd_clk = ~rd_clk;   // slower read clock

    fdm_delay_mem #(.DEPTH(D), .DW(8)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_step_en(wr_step_en),
        .wr_store_en(wr_store_en), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_step_en(rd_step_en),
        .rd_drive_en(rd_drive_en), .rd_data(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] mdl [D];
    int wp = 0, rp = 0;
    logic [7:0] exp_q = 0;

    // {req[15:12], is_write[11], rst[10], step[9], qual[8], data[7:0]}
    localparam logic [15:0] VEC [12] = '{
        16'h0_EC0, 16'h0_AC1, 16'h0_9C2, 16'h0_BC3,
        16'h3_700, 16'h6_300, 16'h5_100, 16'h4_300,
        16'h7_200, 16'h7_300, 16'h3_500, 16'h1_300
    };

    task automatic wr_step(input logic r, input logic s, input logic q, input logic [7:0] d);
        @(negedge wr_clk);
        wr_rst = r; wr_step_en = s; wr_store_en = q; wr_data = d;
        @(posedge wr_clk);
        if (r || s) begin
            int a = r ? 0 : wp;
            if (s && q) mdl[a] = d;
            wp = s ? (a + 1) % D : a;
        end
        #1;
        wr_rst = 0; wr_step_en = 0;
    endtask

    task automatic rd_step(input logic r, input logic s, input logic q, input string tag);
        @(negedge rd_clk);
        rd_rst = r; rd_step_en = s; rd_drive_en = q;
        @(posedge rd_clk);
        if (r || s) begin
            int a = r ? 0 : rp;
            if (s) exp_q = q ? mdl[a] : 8'h00;
            rp = s ? (a + 1) % D : a;
        end
        #1;
        rd_rst = 0; rd_step_en = 0;
        n_chk++;
        if (rd_data !== exp_q) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp_q);
        end
    endtask

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Known contents everywhere so masked stores read back old bytes
        wr_step(1, 1, 1, 8'h10);
        for (int k = 1; k < D; k++) wr_step(0, 1, 1, 8'h10 + 8'(k));

        // R3: first word available right after the read reset edge
        rd_step(1, 1, 1, "R3");
        for (int k = 1; k < 4; k++) rd_step(0, 1, 1, "R1");

        // Table: R4 skipped write, R6 masked store, R5 held, R7 quiet output
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][11]) wr_step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
            else            rd_step(VEC[i][10], VEC[i][9], VEC[i][8], tag_of(VEC[i][15:12]));
        end

        // R8: writer and reader both wrap; word 16 overwrites word 0
        wr_step(1, 1, 1, 8'h20);
        for (int k = 1; k <= D; k++) wr_step(0, 1, 1, 8'h20 + 8'(k));
        rd_step(1, 1, 1, "R8");
        for (int k = 1; k <= D; k++) rd_step(0, 1, 1, "R8");

        // R10: stop the read clock, then resume where it left off
        rd_step(1, 1, 1, "R10");
        rd_step(0, 1, 1, "R10");
        @(negedge rd_clk); rd_run = 0;
        #400;
        rd_run = 1;
        for (int k = 0; k < 3; k++) rd_step(0, 1, 1, "R10");
        @(negedge wr_clk); wr_run = 0;
        #300;
        wr_run = 1;
        wr_step(0, 1, 1, 8'h77);
        rd_step(0, 1, 1, "R10");
        rd_step(0, 1, 1, "R10");

        // R9/R2: concurrent stream on different clocks, read reset 4 writes late
        fork
            begin
                wr_step(1, 1, 1, 8'hD0);
                for (int k = 1; k < 12; k++) wr_step(0, 1, 1, 8'hD0 + 8'(k));
            end
            begin
                repeat (4) @(posedge wr_clk);
                #1;
                rd_step(1, 1, 1, "R9");
                for (int k = 1; k < 8; k++) rd_step(0, 1, 1, "R2");
            end
        join

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule